// File: doc/BRIEF.md
# Clock-Correcting RX Elastic Buffer

This block sits between a recovered write clock and a local read clock and carries a stream of decoded bytes across them. Because the two clocks differ by a small frequency offset, the fill level of the buffer drifts. The block holds it near the middle by removing or duplicating whole idle (clock-correction) sequences that the transmitter sends for this purpose. The idle sequence and its length are set by parameters.

On the write side the block matches the idle sequence in the incoming bytes. When the fill level is above an upper latency limit, it drops a matched sequence, optionally always letting one sequence of a run through. On the read side, when the fill level is below a lower limit, it emits a sequence twice. Every correction is reported on a 3-bit code aligned with the output byte. A per-byte flag can mark the first byte of each duplicated sequence. Overflow and underflow are held as sticky errors until the buffer reset.

Top module: `rx_elastic_buffer`

## Requirements
- R1: While and right after `bufRst` is asserted, `overflowErr`, `underflowErr` and `corrStatus` are 0 and `outData` is 0. The buffer then restarts with the pointers preset so that the fill sits at the midpoint of MIN_LAT and MAX_LAT; the preset entries read out as zero bytes.
- R2: Apart from corrections, every written byte appears on `outData` exactly once and in input order.
- R3: An idle sequence is DET_LEN (1, 2 or 4) consecutive input bytes equal to the SEQ_BYTES parameter, first byte in bits 7:0. By default it is 2 bytes, 0xBC then 0x50. Corrections act only at the first byte of a matched sequence.
- R4: When the write-side fill exceeds MAX_LAT at the first byte of a matched sequence, ADJ_LEN bytes (1, 2 or 4; default 2) are removed, starting at that byte.
- R5: The first byte written after removals carries the number of sequences removed since the previous written byte, saturated at 4. It is shown on `corrStatus` as 3'b001 to 3'b100 in the cycle that byte is output; otherwise the code is 3'b000.
- R6: With KEEP_IDLE set (default), at least one sequence of each unbroken run of sequences is passed to the output.
- R7: When the read-side fill is below MIN_LAT and at least ADJ_LEN, and the next byte is the first byte of a sequence, the ADJ_LEN bytes from that byte are output twice. `corrStatus` is 3'b111 on the first byte of the inserted copy.
- R8: With INSERT_FLAG set (default), `outFlag` is 1 only on the first byte of each inserted copy and 0 on every other byte. With it cleared, `outFlag` follows the input disparity bit of each byte.
- R9: The codes 3'b101 and 3'b110 never appear on `corrStatus`.
- R10: A write attempted while the buffer is full is dropped and sets `overflowErr`, which is sticky in the read domain.
- R11: A read attempted while the buffer is empty outputs a zero byte and sets `underflowErr`, which is sticky.
- R12: Asserting and releasing `bufRst` clears both error outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Recovered clock of the incoming byte stream |
| rdClk | input | 1 | Local read clock |
| bufRst | input | 1 | Asynchronous active-high buffer reset for both domains |
| inData | input | 8 | Decoded input byte, one per wrClk |
| inDisp | input | 1 | Running disparity status of the input byte |
| outData | output | 8 | Output byte, one per rdClk |
| outFlag | output | 1 | Inserted-sequence flag or passed disparity |
| corrStatus | output | 3 | Correction code for the current output byte |
| overflowErr | output | 1 | Sticky overflow error, read domain |
| underflowErr | output | 1 | Sticky underflow error |

## Verification
The bench drives the write clock first faster, then slower, than the read clock, so that both removals and duplications occur at runs of two idle sequences. A scoreboard consumes the expected stream according to the reported code. A design that removes the wrong bytes, or that reports a count not matching the bytes it removed, loses alignment with the expected stream. One that drops both sequences of a run breaks the keep-one rule. One that duplicates from an address other than the sequence start, or that raises the flag on the wrong byte, fails at the inserted copy. The bench then stops the read clock and, separately, the write clock, to show that the error bits set, stay set and clear only on the buffer reset.

// File: rtl/eb_pkg.sv
package eb_pkg;

  // one stored buffer entry
  typedef struct packed {
    logic [7:0] data;
    logic       disp;
    logic       start;   // first byte of a matched idle sequence
    logic [2:0] skips;   // sequences removed just before this byte
  } ebEntry_t;

  // one slot of the write-side detection pipe
  typedef struct packed {
    logic [7:0] data;
    logic       disp;
    logic       mark;
  } pipeSlot_t;

  typedef struct packed {
    logic       doWrite;
    logic [2:0] skips;
  } wrCmd_t;

  typedef struct packed {
    logic       advance;
    logic [1:0] offset;
  } rdCmd_t;

endpackage

// File: rtl/eb_datapath.sv
module eb_datapath
  import eb_pkg::*;
#(
  parameter int          DEPTH     = 64,
  parameter int          DET_LEN   = 2,
  parameter logic [31:0] SEQ_BYTES = 32'h0000_50BC,
  parameter int          MID       = 16,
  localparam int         AW        = $clog2(DEPTH),
  localparam int         PW        = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          bufRst,
  input  logic [7:0]    inData,
  input  logic          inDisp,
  input  wrCmd_t        wrCmd,
  input  rdCmd_t        rdCmd,
  output pipeSlot_t     exitSlot,
  output logic [PW-1:0] wrFill,
  output logic [PW-1:0] rdFill,
  output ebEntry_t      rdEntry
);

  localparam int            PIPE  = 5;
  localparam logic [PW-1:0] MID_B = PW'(MID);
  localparam logic [PW-1:0] MID_G = MID_B ^ (MID_B >> 1);

  pipeSlot_t pipe [PIPE];
  logic      seqHit;

  // sequence match over the newest DET_LEN bytes
  always_comb begin
    seqHit = 1'b1;
    for (int k = 0; k < DET_LEN; k++)
      if (pipe[DET_LEN-1-k].data != SEQ_BYTES[8*k +: 8]) seqHit = 1'b0;
  end

  always_ff @(posedge wrClk or posedge bufRst) begin
    if (bufRst) begin
      for (int i = 0; i < PIPE; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= '{data: inData, disp: inDisp, mark: 1'b0};
      for (int i = 1; i < PIPE; i++) begin
        if (i == DET_LEN)
          pipe[i] <= '{data: pipe[i-1].data, disp: pipe[i-1].disp,
                       mark: pipe[i-1].mark | seqHit};
        else
          pipe[i] <= pipe[i-1];
      end
    end
  end

  assign exitSlot = pipe[PIPE-1];

  ebEntry_t      mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [PW-1:0] wrSync1, wrSync2, rdSync1, rdSync2;
  logic [PW-1:0] wrSyncBin, rdSyncBin;

  always_ff @(posedge wrClk or posedge bufRst) begin
    if (bufRst) begin
      wrPtr <= MID_B;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wrCmd.doWrite) begin
      mem[wrPtr[AW-1:0]] <= '{data: exitSlot.data, disp: exitSlot.disp,
                             start: exitSlot.mark, skips: wrCmd.skips};
      wrPtr <= wrPtr + 1'b1;
    end
  end

  always_ff @(posedge rdClk or posedge bufRst) begin
    if (bufRst)              rdPtr <= '0;
    else if (rdCmd.advance)  rdPtr <= rdPtr + 1'b1;
  end

  // Gray pointers through two-flop synchronisers
  always_ff @(posedge rdClk or posedge bufRst) begin
    if (bufRst) begin
      wrSync1 <= MID_G;
      wrSync2 <= MID_G;
    end else begin
      wrSync1 <= wrPtr ^ (wrPtr >> 1);
      wrSync2 <= wrSync1;
    end
  end

  always_ff @(posedge wrClk or posedge bufRst) begin
    if (bufRst) begin
      rdSync1 <= '0;
      rdSync2 <= '0;
    end else begin
      rdSync1 <= rdPtr ^ (rdPtr >> 1);
      rdSync2 <= rdSync1;
    end
  end

  always_comb begin
    for (int i = 0; i < PW; i++) begin
      wrSyncBin[i] = ^(wrSync2 >> i);
      rdSyncBin[i] = ^(rdSync2 >> i);
    end
  end

  assign wrFill  = wrPtr - rdSyncBin;
  assign rdFill  = wrSyncBin - rdPtr;
  assign rdEntry = mem[rdPtr[AW-1:0] + AW'(rdCmd.offset)];

  // R7: the read pointer stays put whenever control does not advance it
  p_rdptr_hold_r7: assert property (@(posedge rdClk) disable iff (bufRst)
    !rdCmd.advance |=> $stable(rdPtr))
    else $error("p_rdptr_hold_r7");

  // R10: control never commits a write into a full buffer
  p_no_write_full_r10: assert property (@(posedge wrClk) disable iff (bufRst)
    wrCmd.doWrite |-> (wrFill < PW'(DEPTH)))
    else $error("p_no_write_full_r10");

endmodule

// File: rtl/eb_ctrl.sv
module eb_ctrl
  import eb_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int MIN_LAT     = 8,
  parameter int MAX_LAT     = 24,
  parameter int DET_LEN     = 2,
  parameter int ADJ_LEN     = 2,
  parameter bit KEEP_IDLE   = 1'b1,
  parameter bit INSERT_FLAG = 1'b1,
  localparam int PW         = $clog2(DEPTH) + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          bufRst,
  input  pipeSlot_t     exitSlot,
  input  logic [PW-1:0] wrFill,
  input  logic [PW-1:0] rdFill,
  input  ebEntry_t      rdEntry,
  output wrCmd_t        wrCmd,
  output rdCmd_t        rdCmd,
  output logic [7:0]    outData,
  output logic          outFlag,
  output logic [2:0]    corrStatus,
  output logic          overflowErr,
  output logic          underflowErr
);

  // ---------------- write side: removal ----------------
  logic [1:0] skipLeft, seqLeft;
  logic [2:0] pendSkips;
  logic       runKept, ovfWr, ovfS1;
  logic       consumeSkip, skipNow, wantWrite, overWrite;

  always_comb begin
    consumeSkip   = (skipLeft != 2'd0);
    skipNow       = !consumeSkip && exitSlot.mark && (wrFill > PW'(MAX_LAT))
                    && (!KEEP_IDLE || runKept);
    wantWrite     = !consumeSkip && !skipNow;
    overWrite     = wantWrite && (wrFill >= PW'(DEPTH));
    wrCmd.doWrite = wantWrite && !overWrite;
    wrCmd.skips   = pendSkips;
  end

  always_ff @(posedge wrClk or posedge bufRst) begin
    if (bufRst) begin
      skipLeft  <= '0;
      seqLeft   <= '0;
      pendSkips <= '0;
      runKept   <= 1'b0;
      ovfWr     <= 1'b0;
    end else begin
      if (consumeSkip)  skipLeft <= skipLeft - 1'b1;
      else if (skipNow) skipLeft <= 2'(ADJ_LEN - 1);

      if (skipNow)            pendSkips <= (pendSkips == 3'd4) ? 3'd4 : pendSkips + 1'b1;
      else if (wrCmd.doWrite) pendSkips <= '0;

      if (exitSlot.mark)        seqLeft <= 2'(DET_LEN - 1);
      else if (seqLeft != 2'd0) seqLeft <= seqLeft - 1'b1;

      if (exitSlot.mark && wrCmd.doWrite)          runKept <= 1'b1;
      else if (!exitSlot.mark && seqLeft == 2'd0)  runKept <= 1'b0;

      if (overWrite) ovfWr <= 1'b1;
    end
  end

  // ---------------- read side: repetition ----------------
  logic [1:0] repLeft, repOff;
  logic       noRepeat, startRep, rdEmpty;

  always_comb begin
    rdEmpty       = (rdFill == '0);
    startRep      = (repLeft == 2'd0) && !rdEmpty && rdEntry.start && !noRepeat
                    && (rdFill < PW'(MIN_LAT)) && (rdFill >= PW'(ADJ_LEN));
    rdCmd.advance = (repLeft == 2'd0) && !rdEmpty && !startRep;
    rdCmd.offset  = repOff;
  end

  always_ff @(posedge rdClk or posedge bufRst) begin
    if (bufRst) begin
      outData      <= '0;
      outFlag      <= 1'b0;
      corrStatus   <= 3'b000;
      repLeft      <= '0;
      repOff       <= '0;
      noRepeat     <= 1'b0;
      underflowErr <= 1'b0;
      ovfS1        <= 1'b0;
      overflowErr  <= 1'b0;
    end else begin
      ovfS1       <= ovfWr;
      overflowErr <= ovfS1;
      if (repLeft != 2'd0) begin
        outData    <= rdEntry.data;
        outFlag    <= INSERT_FLAG ? 1'b0 : rdEntry.disp;
        corrStatus <= 3'b000;
        repLeft    <= repLeft - 1'b1;
        repOff     <= (repLeft == 2'd1) ? 2'd0 : repOff + 1'b1;
      end else if (rdEmpty) begin
        outData      <= '0;
        outFlag      <= 1'b0;
        corrStatus   <= 3'b000;
        underflowErr <= 1'b1;
      end else if (startRep) begin
        outData    <= rdEntry.data;
        outFlag    <= INSERT_FLAG ? 1'b1 : rdEntry.disp;
        corrStatus <= 3'b111;
        noRepeat   <= 1'b1;
        repLeft    <= 2'(ADJ_LEN - 1);
        repOff     <= 2'((ADJ_LEN > 1) ? 1 : 0);
      end else begin
        outData    <= rdEntry.data;
        outFlag    <= INSERT_FLAG ? 1'b0 : rdEntry.disp;
        corrStatus <= rdEntry.skips;
        noRepeat   <= 1'b0;
      end
    end
  end

  // R4: a removal also swallows the following bytes of the adjustment
  p_skip_consumes_r4: assert property (@(posedge wrClk) disable iff (bufRst)
    (skipNow && ADJ_LEN > 1) |=> !wrCmd.doWrite)
    else $error("p_skip_consumes_r4");

  // R8: in flag mode the flag only accompanies an inserted-copy code
  p_flag_on_insert_r8: assert property (@(posedge rdClk) disable iff (bufRst)
    (INSERT_FLAG && outFlag) |-> (corrStatus == 3'b111))
    else $error("p_flag_on_insert_r8");

  // R9: unused codes never reach the output
  p_codes_r9: assert property (@(posedge rdClk) disable iff (bufRst)
    (corrStatus != 3'b101) && (corrStatus != 3'b110))
    else $error("p_codes_r9");

  // R10: overflow error is sticky
  p_ovf_sticky_r10: assert property (@(posedge rdClk) disable iff (bufRst)
    overflowErr |=> overflowErr)
    else $error("p_ovf_sticky_r10");

  // R11: underflow error is sticky
  p_unf_sticky_r11: assert property (@(posedge rdClk) disable iff (bufRst)
    underflowErr |=> underflowErr)
    else $error("p_unf_sticky_r11");

endmodule

// File: rtl/rx_elastic_buffer.sv
module rx_elastic_buffer
  import eb_pkg::*;
#(
  parameter int          DEPTH       = 64,
  parameter int          MIN_LAT     = 8,
  parameter int          MAX_LAT     = 24,
  parameter int          DET_LEN     = 2,
  parameter int          ADJ_LEN     = 2,
  parameter logic [31:0] SEQ_BYTES   = 32'h0000_50BC,
  parameter bit          KEEP_IDLE   = 1'b1,
  parameter bit          INSERT_FLAG = 1'b1,
  localparam int         PW          = $clog2(DEPTH) + 1,
  localparam int         MID         = (MIN_LAT + MAX_LAT) / 2
) (
  input  logic       wrClk,
  input  logic       rdClk,
  input  logic       bufRst,
  input  logic [7:0] inData,
  input  logic       inDisp,
  output logic [7:0] outData,
  output logic       outFlag,
  output logic [2:0] corrStatus,
  output logic       overflowErr,
  output logic       underflowErr
);

  wrCmd_t        wrCmd;
  rdCmd_t        rdCmd;
  pipeSlot_t     exitSlot;
  ebEntry_t      rdEntry;
  logic [PW-1:0] wrFill, rdFill;

  eb_datapath #(
    .DEPTH(DEPTH), .DET_LEN(DET_LEN), .SEQ_BYTES(SEQ_BYTES), .MID(MID)
  ) u_datapath (
    .wrClk(wrClk), .rdClk(rdClk), .bufRst(bufRst),
    .inData(inData), .inDisp(inDisp),
    .wrCmd(wrCmd), .rdCmd(rdCmd),
    .exitSlot(exitSlot), .wrFill(wrFill), .rdFill(rdFill), .rdEntry(rdEntry)
  );

  eb_ctrl #(
    .DEPTH(DEPTH), .MIN_LAT(MIN_LAT), .MAX_LAT(MAX_LAT),
    .DET_LEN(DET_LEN), .ADJ_LEN(ADJ_LEN),
    .KEEP_IDLE(KEEP_IDLE), .INSERT_FLAG(INSERT_FLAG)
  ) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .bufRst(bufRst),
    .exitSlot(exitSlot), .wrFill(wrFill), .rdFill(rdFill), .rdEntry(rdEntry),
    .wrCmd(wrCmd), .rdCmd(rdCmd),
    .outData(outData), .outFlag(outFlag), .corrStatus(corrStatus),
    .overflowErr(overflowErr), .underflowErr(underflowErr)
  );

endmodule

// File: tb/rx_elastic_buffer_bench.sv
`timescale 1ns/1ps
module rx_elastic_buffer_bench;

  localparam int ADJ = 2;

  logic       wrClk = 1'b0, rdClk = 1'b0, bufRst = 1'b1;
  logic [7:0] inData = '0;
  logic       inDisp = 1'b0;
  logic [7:0] outData;
  logic       outFlag, overflowErr, underflowErr;
  logic [2:0] corrStatus;

  real wrHalf = 4.9;
  bit  wrRun = 1'b1, rdRun = 1'b1;

  always begin #(wrHalf); if (wrRun) wrClk = ~wrClk; end
  always begin #5;        if (rdRun) rdClk = ~rdClk; end

  rx_elastic_buffer u_rx_elastic_buffer (
    .wrClk(wrClk), .rdClk(rdClk), .bufRst(bufRst),
    .inData(inData), .inDisp(inDisp),
    .outData(outData), .outFlag(outFlag), .corrStatus(corrStatus),
    .overflowErr(overflowErr), .underflowErr(underflowErr)
  );

  // kind: 0 data, 1 first idle start of a run, 2 second idle start, 3 idle tail
  typedef struct packed { logic [7:0] data; logic [1:0] kind; } item_t;
  item_t expQ[$];

  int checks = 0, errors = 0, repIdx = 0, skipSeen = 0, repSeen = 0;
  bit pushOn = 1'b0, monOn = 1'b0, started = 1'b0, seqOn = 1'b1, done = 1'b0;
  int blkPos = 0;
  logic [7:0] dataCnt = 8'h01;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic item_t popExp();
    item_t it = '0;
    if (expQ.size() > 0) it = expQ.pop_front();
    return it;
  endfunction

  // driver: one byte per write clock, pushed to the scoreboard queue
  task automatic driveByte();
    item_t it;
    if (!pushOn) begin
      it = '0;
    end else if (seqOn && blkPos >= 10) begin
      case (blkPos)
        10: it = '{data: 8'hBC, kind: 2'd1};
        12: it = '{data: 8'hBC, kind: 2'd2};
        default: it = '{data: 8'h50, kind: 2'd3};
      endcase
    end else begin
      it = '{data: dataCnt, kind: 2'd0};
      dataCnt = (dataCnt == 8'h7F) ? 8'h01 : dataCnt + 8'h01;
      if (dataCnt == 8'h50) dataCnt = 8'h51;
    end
    if (pushOn) begin
      blkPos = (blkPos == 13) ? 0 : blkPos + 1;
      expQ.push_back(it);
    end
    inData = it.data;
    inDisp = ^it.data;
  endtask

  initial forever begin
    @(negedge wrClk);
    driveByte();
  end

  // monitor: compares each output byte against the expected stream
  task automatic sampleOut();
    item_t it;
    if (!started) begin
      if (outData == 8'h00) return;
      started = 1'b1;
    end
    if (corrStatus == 3'b101 || corrStatus == 3'b110) begin
      check(1'b0, "R9 unused code", corrStatus, 0);
    end else if (corrStatus == 3'b111) begin
      repSeen++;
      check(expQ.size() > 0 && outData == expQ[0].data, "R7 inserted first byte",
            outData, (expQ.size() > 0) ? expQ[0].data : 0);
      check(expQ.size() > 0 && (expQ[0].kind == 2'd1 || expQ[0].kind == 2'd2),
            "R3 insert at sequence start", (expQ.size() > 0) ? expQ[0].kind : 0, 1);
      check(outFlag == 1'b1, "R8 flag on first inserted", outFlag, 1);
      repIdx = (ADJ > 1) ? 1 : 0;
    end else if (corrStatus != 3'b000) begin
      skipSeen++;
      check(corrStatus <= 3'b100, "R5 skip code range", corrStatus, 1);
      check(corrStatus == 3'b001, "R6 keep one per run", corrStatus, 1);
      for (int s = 0; s < int'(corrStatus) * ADJ; s++) begin
        it = popExp();
        if (s % 2 == 0) begin
          check(it.kind == 2'd1 || it.kind == 2'd2, "R4 removal at start", it.kind, 2);
          if (s == 0) check(it.kind == 2'd2, "R6 first of run kept", it.kind, 2);
        end else begin
          check(it.kind == 2'd3, "R4 removal length", it.kind, 3);
        end
      end
      it = popExp();
      check(outData == it.data, "R5 byte after removal", outData, it.data);
      check(outFlag == 1'b0, "R8 flag low", outFlag, 0);
    end else if (repIdx > 0) begin
      check(expQ.size() > repIdx && outData == expQ[repIdx].data, "R7 inserted copy",
            outData, (expQ.size() > repIdx) ? expQ[repIdx].data : 0);
      check(outFlag == 1'b0, "R8 flag low in copy", outFlag, 0);
      repIdx = (repIdx + 1 == ADJ) ? 0 : repIdx + 1;
    end else begin
      it = popExp();
      check(outData == it.data, "R2 stream order", outData, it.data);
      check(outFlag == 1'b0, "R8 flag low", outFlag, 0);
    end
  endtask

  initial forever begin
    @(negedge rdClk);
    if (monOn) sampleOut();
  end

  task automatic pulseReset();
    bufRst = 1'b1;
    #40;
    bufRst = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge rdClk);
    check(outData == 8'h00 && corrStatus == 3'b000, "R1 reset outputs", outData, 0);
    check(overflowErr == 1'b0 && underflowErr == 1'b0, "R1 reset errors",
          {overflowErr, underflowErr}, 0);
    @(negedge rdClk);
    bufRst = 1'b0;
    @(posedge wrClk);
    pushOn = 1'b1;
    monOn  = 1'b1;
    @(negedge rdClk);
    check(outData == 8'h00 && corrStatus == 3'b000, "R1 preset entries are zero",
          outData, 0);

    // write faster than read: removals expected
    repeat (1500) @(posedge wrClk);
    // write slower than read: insertions expected
    wrHalf = 5.15;
    repeat (2500) @(posedge wrClk);
    monOn = 1'b0;
    check(skipSeen > 0, "R4 removals occurred", skipSeen, 1);
    check(repSeen > 0, "R7 insertions occurred", repSeen, 1);
    check(overflowErr == 1'b0 && underflowErr == 1'b0, "R10 R11 no error in tracking",
          {overflowErr, underflowErr}, 0);

    // overflow: stop the reader
    pushOn = 1'b0;
    seqOn  = 1'b0;
    wrHalf = 5.0;
    rdRun  = 1'b0;
    repeat (120) @(posedge wrClk);
    rdRun = 1'b1;
    repeat (6) @(negedge rdClk);
    check(overflowErr == 1'b1, "R10 overflow set", overflowErr, 1);
    repeat (10) @(negedge rdClk);
    check(overflowErr == 1'b1, "R10 overflow sticky", overflowErr, 1);
    pulseReset();
    @(negedge rdClk);
    check(overflowErr == 1'b0 && underflowErr == 1'b0, "R12 cleared after overflow",
          {overflowErr, underflowErr}, 0);

    // underflow: stop the writer
    repeat (5) @(negedge rdClk);
    wrRun = 1'b0;
    repeat (60) @(negedge rdClk);
    check(underflowErr == 1'b1, "R11 underflow set", underflowErr, 1);
    check(outData == 8'h00, "R11 empty read gives zero", outData, 0);
    wrRun = 1'b1;
    repeat (20) @(negedge rdClk);
    check(underflowErr == 1'b1, "R11 underflow sticky", underflowErr, 1);
    pulseReset();
    @(negedge rdClk);
    check(overflowErr == 1'b0 && underflowErr == 1'b0, "R12 cleared after underflow",
          {overflowErr, underflowErr}, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule